// File: doc/BRIEF.md
# Overcurrent Pulse Qualification Timer

This block sits behind the current-limit comparators of a buck converter. It decides when a run of high-current PWM pulses counts as a sustained overcurrent fault, and when a short-circuit level has lasted long enough to be declared. The overcurrent flag is sampled only when the PWM pulse strobe is high. The first sample above the limit starts a qualification window counted in microsecond ticks. Any later pulse that samples the current below the limit discards the window. The overcurrent fault is declared only if the window runs to its end with every pulse inside it above the limit.

A second, shorter path runs alongside. It watches the short-circuit flag, which means the current is above twice the overcurrent limit. If that flag stays high for the short window, a short-circuit fault is declared. Each path issues a single-cycle fault pulse to a downstream fault latch and then stays silent until the active-low clear input is asserted. Both window lengths are parameters in tick units and default to 20 and 10.

Top module: `ocq_qualifier`

## Requirements
- R1: After reset both fault outputs are low and both window timers are idle.
- R2: The overcurrent flag has an effect only in cycles where pwm_strobe_i is high. If no strobe occurs, the overcurrent flag never starts a window and never causes a fault.
- R3: A strobe that samples an over-limit current arms the overcurrent timer at zero. A tick in that same cycle is not counted. If no under-limit strobe follows, ocp_fault_o pulses in the cycle after the clock edge that takes the OC_WIN_TICKS-th later tick.
- R4: A strobe that samples an under-limit current disarms the overcurrent timer and zeroes it. A tick in that same cycle is discarded. Only a new over-limit strobe arms the timer again.
- R5: Over-limit strobes that arrive while the timer is armed do not restart or alter the count.
- R6: On a strobe, a high sc_flag_i counts as an over-limit sample even when oc_flag_i is low, because the short-circuit level is twice the overcurrent level.
- R7: The cycle in which sc_flag_i is first seen high arms the short-circuit timer at zero, and a tick in that cycle is not counted. If the flag then stays high, scp_fault_o pulses in the cycle after the edge that takes the SC_WIN_TICKS-th later tick.
- R8: Any cycle in which sc_flag_i is low zeroes and disarms the short-circuit timer.
- R9: Each fault pulse lasts exactly one cycle. After a path has pulsed, that path issues no further pulse until clear_ni is driven low.
- R10: While clear_ni is low, both timers are held at zero and disarmed, no fault pulse is issued in the following cycle, and both paths are enabled to report again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_strobe_i | input | 1 | One-cycle strobe per PWM pulse; the current flags are sampled on it |
| oc_flag_i | input | 1 | Sense current is above the overcurrent limit |
| sc_flag_i | input | 1 | Sense current is above twice the overcurrent limit |
| tick_i | input | 1 | One-cycle microsecond time base |
| clear_ni | input | 1 | Synchronous active-low clear of timers and report state |
| ocp_fault_o | output | 1 | One-cycle overcurrent fault pulse |
| scp_fault_o | output | 1 | One-cycle short-circuit fault pulse |

## Verification
The assertions check on every cycle that an under-limit strobe leaves the overcurrent timer disarmed at zero and that an expiring timer disarms. They also check that every fault pulse lasts one cycle, that a path which has reported stays silent, that clear suppresses output, and that each fault pulse follows a tick, with the short-circuit pulse also following a high short-circuit flag. The exact cycle of each pulse can only be shown by the bench's scenarios. The same holds for how strobes and ticks that land in the same cycle interact, for the rule that the flag is ignored without a strobe, and for restarting after clear. The bench covers these with directed sequences and with a long random run that it compares cycle by cycle against its own model of the requirements.

// File: rtl/ocq_pkg.sv
package ocq_pkg;
  function automatic int ocq_cnt_width(input int win);
    return (win < 2) ? 1 : $clog2(win + 1);
  endfunction
endpackage

// File: rtl/ocq_tick_timer.sv
module ocq_tick_timer #(
  parameter int WIN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic restart_i,
  input  logic arm_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = ocq_pkg::ocq_cnt_width(WIN);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          kill;

  assign kill     = clr_i | restart_i;
  assign expire_o = armed_q & tick_i & (cnt_q == LAST) & ~kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (kill) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      if (arm_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !clr_i) |=> (!armed_q && cnt_q == '0));

  // R3
  expire_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !armed_q);
endmodule

// File: rtl/ocq_report_once.sv
module ocq_report_once (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  output logic pulse_o
);
  logic done_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      done_q  <= done_q | hit_i;
      pulse_q <= hit_i & ~done_q;
    end
  end

  assign pulse_o = pulse_q;

  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R9
  silent_after_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> !pulse_o);
endmodule

// File: rtl/ocq_qualifier.sv
module ocq_qualifier #(
  parameter int OC_WIN_TICKS = 20,
  parameter int SC_WIN_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_strobe_i,
  input  logic oc_flag_i,
  input  logic sc_flag_i,
  input  logic tick_i,
  input  logic clear_ni,
  output logic ocp_fault_o,
  output logic scp_fault_o
);
  logic clr;
  logic over_lim;
  logic oc_good_pulse;
  logic oc_bad_pulse;
  logic oc_expire;
  logic sc_expire;

  assign clr           = ~clear_ni;
  // short-circuit level is twice the limit, so it implies over-limit
  assign over_lim      = oc_flag_i | sc_flag_i;
  assign oc_good_pulse = pwm_strobe_i & over_lim;
  assign oc_bad_pulse  = pwm_strobe_i & ~over_lim;

  ocq_tick_timer #(.WIN(OC_WIN_TICKS)) u_oc_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .restart_i (oc_bad_pulse),
    .arm_i     (oc_good_pulse),
    .tick_i    (tick_i),
    .expire_o  (oc_expire)
  );

  ocq_tick_timer #(.WIN(SC_WIN_TICKS)) u_sc_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .restart_i (~sc_flag_i),
    .arm_i     (sc_flag_i),
    .tick_i    (tick_i),
    .expire_o  (sc_expire)
  );

  ocq_report_once u_oc_report (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .hit_i   (oc_expire),
    .pulse_o (ocp_fault_o)
  );

  ocq_report_once u_sc_report (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .hit_i   (sc_expire),
    .pulse_o (scp_fault_o)
  );

  // R10
  clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |=> (!ocp_fault_o && !scp_fault_o));

  // R7
  scp_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scp_fault_o |-> $past(sc_flag_i && tick_i));

  // R3
  ocp_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_fault_o |-> $past(tick_i));
endmodule

// File: tb/ocq_qualifier_test.sv
module ocq_qualifier_test;
  localparam int OW = 20;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, oc = 1'b0, sc = 1'b0, tick = 1'b0, clr_n = 1'b1;
  logic ocp, scp;

  int checks = 0;
  int errors = 0;
  int n_ocp = 0;
  int n_scp = 0;
  string cur_req = "R1";

  // model state
  bit m_oarm, m_odone, m_sarm, m_sdone;
  int m_ocnt, m_scnt;
  bit e_ocp, e_scp;

  always #5 clk = ~clk;

  ocq_qualifier #(.OC_WIN_TICKS(OW), .SC_WIN_TICKS(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_strobe_i(strobe), .oc_flag_i(oc),
    .sc_flag_i(sc), .tick_i(tick), .clear_ni(clr_n),
    .ocp_fault_o(ocp), .scp_fault_o(scp)
  );

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic void model_reset();
    m_oarm = 0; m_odone = 0; m_sarm = 0; m_sdone = 0;
    m_ocnt = 0; m_scnt = 0;
  endfunction

  // next-state model built from R2..R10
  function automatic void model_step(bit s, bit o, bit c, bit t, bit cn);
    bit clr = !cn;
    bit over = o | c;
    bit ohit = 0, shit = 0;
    if (clr || (s && !over)) begin m_oarm = 0; m_ocnt = 0; end
    else if (!m_oarm) begin if (s) begin m_oarm = 1; m_ocnt = 0; end end
    else if (t) begin
      if (m_ocnt == OW - 1) begin ohit = 1; m_oarm = 0; m_ocnt = 0; end
      else m_ocnt++;
    end
    if (clr || !c) begin m_sarm = 0; m_scnt = 0; end
    else if (!m_sarm) begin m_sarm = 1; m_scnt = 0; end
    else if (t) begin
      if (m_scnt == SW - 1) begin shit = 1; m_sarm = 0; m_scnt = 0; end
      else m_scnt++;
    end
    e_ocp = ohit && !m_odone && !clr;
    e_scp = shit && !m_sdone && !clr;
    m_odone = clr ? 0 : (m_odone | ohit);
    m_sdone = clr ? 0 : (m_sdone | shit);
  endfunction

  // drive at negedge, sample at next negedge
  task automatic step(input bit s, input bit o, input bit c, input bit t, input bit cn = 1);
    strobe = s; oc = o; sc = c; tick = t; clr_n = cn;
    model_step(s, o, c, t, cn);
    @(posedge clk);
    @(negedge clk);
    check(cur_req, ocp, e_ocp, "ocp_fault_o");
    check(cur_req, scp, e_scp, "scp_fault_o");
    if (ocp) n_ocp++;
    if (scp) n_scp++;
  endtask

  task automatic do_clear();
    step(0, 0, 0, 0, 0);
    n_ocp = 0; n_scp = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", ocp, 0, "ocp in reset");
    check("R1", scp, 0, "scp in reset");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 1);

    // R2: flag high, ticks, no strobe
    cur_req = "R2"; do_clear();
    for (int i = 0; i < 3 * OW; i++) step(0, 1, 0, 1);
    check("R2", n_ocp, 0, "ocp count without strobe");

    // R3 and R5: arm with a tick in the same cycle, good strobes while armed
    cur_req = "R3"; do_clear();
    step(1, 1, 0, 1);
    for (int i = 0; i < OW - 1; i++) step((i % 3) == 0, 1, 0, 1);
    check("R3", n_ocp, 0, "ocp before last tick");
    step(0, 1, 0, 1);
    check("R3", n_ocp, 1, "ocp on last tick");
    check("R5", n_ocp, 1, "good strobes did not restart count");

    // R4: bad strobe with tick discards window
    cur_req = "R4"; do_clear();
    step(1, 1, 0, 0);
    for (int i = 0; i < OW - 2; i++) step(0, 1, 0, 1);
    step(1, 0, 0, 1);
    for (int i = 0; i < OW; i++) step(0, 1, 0, 1);
    check("R4", n_ocp, 0, "ocp after bad strobe without rearm");
    step(1, 1, 0, 0);
    for (int i = 0; i < OW; i++) step(0, 0, 0, 1);
    check("R4", n_ocp, 1, "ocp after rearm");

    // R6: short-circuit level counts as over-limit on a strobe
    cur_req = "R6"; do_clear();
    step(1, 0, 1, 0);
    for (int i = 0; i < OW; i++) step(0, 0, 0, 1);
    check("R6", n_ocp, 1, "ocp armed by sc flag");

    // R7: short-circuit window, tick in first cycle ignored
    cur_req = "R7"; do_clear();
    step(0, 1, 1, 1);
    for (int i = 0; i < SW - 1; i++) step(0, 1, 1, 1);
    check("R7", n_scp, 0, "scp before last tick");
    step(0, 1, 1, 1);
    check("R7", n_scp, 1, "scp on last tick");

    // R8: flag drop restarts
    cur_req = "R8"; do_clear();
    step(0, 1, 1, 0);
    for (int i = 0; i < SW - 1; i++) step(0, 1, 1, 1);
    step(0, 1, 0, 1);
    step(0, 1, 1, 0);
    for (int i = 0; i < SW - 1; i++) step(0, 1, 1, 1);
    check("R8", n_scp, 0, "scp after drop");
    step(0, 1, 1, 1);
    check("R8", n_scp, 1, "scp after full window");

    // R9: sustained condition reports once
    cur_req = "R9"; do_clear();
    step(1, 1, 1, 0);
    for (int i = 0; i < 4 * OW; i++) step((i % 2) == 0, 1, 1, 1);
    check("R9", n_ocp, 1, "single ocp report");
    check("R9", n_scp, 1, "single scp report");

    // R10: clear rearms reporting; clear on expiring tick suppresses
    cur_req = "R10"; do_clear();
    for (int i = 0; i < 3 * SW; i++) step(0, 1, 1, 1, (i % 5) != 4);
    check("R10", n_scp, 0, "no scp under periodic clear");
    do_clear();
    step(0, 1, 1, 0);
    for (int i = 0; i < SW; i++) step(0, 1, 1, 1);
    check("R10", n_scp, 1, "scp after clear");

    // random phase
    cur_req = "R3 R7";
    begin
      bit sc_reg = 0;
      for (int i = 0; i < 20000; i++) begin
        bit s, o, t, cn;
        if (($urandom % 40) == 0) sc_reg = !sc_reg;
        s  = ($urandom % 4) == 0;
        o  = sc_reg ? 1'b1 : (($urandom % 60) != 0);
        t  = ($urandom % 3) == 0;
        cn = ($urandom % 300) != 0;
        step(s, o, sc_reg, t, cn);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule